// File: doc/BRIEF.md
# Command Frame Transmitter with XOR Check Byte

This block serialises one command frame at a time onto a byte-wide valid/ready stream that feeds a serial PHY. A host loads a header with a 3-bit message class, a 5-bit routing field, an 8-bit opcode and a payload length, all in one strobe. The block then sends the frame in a fixed order: a start marker, the length in two bytes, a packed class/routing byte, the opcode, the payload bytes taken from a separate valid/ready input stream, and a closing check byte. The check byte is the XOR of every byte after the start marker, and it is built while the frame goes out.

Class code 1 marks a blocking request. When a class-1 header is accepted, an interlock is set. While it is set, any further class-1 header is refused. The interlock is cleared by a strobe from the receive side saying that the matching response (class 3) has arrived. Headers of other classes are not held back by the interlock. A header load is also refused while a frame is still in flight. A single-cycle completion strobe follows each frame.

Top module: `cmd_frame_tx`

## Requirements
- R1: After a header is accepted, the first byte offered on `tx_data` is 0xFE.
- R2: The next two bytes are the length, low byte first. The second byte carries length bits 13:8, and its two upper bits are always zero.
- R3: The fourth byte is `{hdr_type, hdr_subsys}`, with the class in bits 7:5 and the routing field in bits 4:0. The fifth byte is `hdr_cmd`.
- R4: Exactly `hdr_len` payload bytes pass from `pl_data` to `tx_data` in arrival order. While a payload byte is owed and `pl_valid` is low, `tx_valid` stays low. `pl_ready` is never high outside the payload phase.
- R5: The last byte of each frame is the XOR of all bytes after the 0xFE marker: both length bytes, the class/routing byte, the opcode and every payload byte.
- R6: `hdr_ready` is low from the cycle after a header is accepted until the check byte has been accepted. A `hdr_load` seen while `hdr_ready` is low has no effect.
- R7: Accepting a class-1 header sets the interlock. While the interlock is set, `hdr_ready` is low whenever `hdr_type` is 1. Other classes can still be loaded.
- R8: A `resp_seen` pulse clears the interlock in the following cycle. If a class-1 header is accepted in the same cycle, setting the interlock wins over clearing it.
- R9: `frame_done` is high for exactly one cycle, in the cycle after the check byte is accepted.
- R10: While `tx_valid` is high and `tx_ready` is low, any byte other than a payload byte holds its value.
- R11: While reset is active (and after it releases), `tx_valid`, `pl_ready` and `frame_done` are low, the interlock is clear, and `hdr_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hdr_load | input | 1 | Header load strobe, taken when `hdr_ready` is high |
| hdr_type | input | 3 | Message class (1 = blocking request, 3 = response) |
| hdr_subsys | input | 5 | Routing field |
| hdr_cmd | input | 8 | Opcode byte |
| hdr_len | input | LEN_W (14) | Payload length in bytes |
| hdr_ready | output | 1 | Header can be accepted this cycle |
| pl_valid | input | 1 | Payload byte available |
| pl_data | input | 8 | Payload byte |
| pl_ready | output | 1 | Payload byte taken this cycle |
| tx_valid | output | 1 | Output byte available |
| tx_data | output | 8 | Output byte |
| tx_ready | input | 1 | PHY accepts the output byte |
| resp_seen | input | 1 | Receive side has seen a response, clears the interlock |
| frame_done | output | 1 | One-cycle pulse after the check byte is accepted |

## Verification
The checker module tests several rules on every cycle. It checks that the start marker follows an accepted load, that loads are refused while a frame is in flight or while the interlock blocks a class-1 header, and that `resp_seen` clears the interlock. It also checks that non-payload bytes stay stable under back-pressure, that `pl_ready` appears only in the payload phase, and that the completion pulse lasts one cycle. Only the bench scenarios can show that the whole byte sequence is right: the length split including a length whose high byte is non-zero, payload order when the source has gaps, and the value of the XOR check byte. Those scenarios include zero-length frames, a full 14-bit length, and a request/response interlock sequence.

// File: rtl/cft_pkg.sv
// Package: shared constants, state encoding and byte packing for the
// command frame transmitter. Assumes an 8-bit class/routing byte split 3/5.
package cft_pkg;

    localparam int          TYPE_W    = 3;
    localparam int          SUB_W     = 5;
    localparam logic [7:0]  SOF_BYTE  = 8'hFE;
    localparam logic [2:0]  TYPE_SREQ = 3'd1;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SOF    = 3'd1,
        ST_LEN_LO = 3'd2,
        ST_LEN_HI = 3'd3,
        ST_HDR    = 3'd4,
        ST_CMD    = 3'd5,
        ST_PAY    = 3'd6,
        ST_FCS    = 3'd7
    } cft_state_e;

    // Packs class into the top bits and routing into the low bits.
    function automatic logic [7:0] pack_hdr(input logic [TYPE_W-1:0] t,
                                            input logic [SUB_W-1:0]  s);
        return {t, s};
    endfunction

endpackage

// File: rtl/cft_sequencer.sv
// Module: frame phase sequencer. Walks the frame phases in fixed order and
// counts payload bytes still owed. Assumes start is only raised in ST_IDLE
// and that fire means the current byte was accepted downstream.
module cft_sequencer
    import cft_pkg::*;
#(
    parameter int LEN_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] len,
    input  logic             fire,
    output cft_state_e       st,
    output logic             frame_end
);

    localparam logic [LEN_W-1:0] ONE = {{(LEN_W-1){1'b0}}, 1'b1};

    cft_state_e       st_n;
    logic [LEN_W-1:0] remain_q;
    logic [LEN_W-1:0] remain_n;

    // Next phase and remaining-count logic.
    always_comb begin
        st_n     = st;
        remain_n = remain_q;
        unique case (st)
            ST_IDLE: begin
                if (start) begin
                    st_n     = ST_SOF;
                    remain_n = len;
                end
            end
            ST_SOF:    if (fire) st_n = ST_LEN_LO;
            ST_LEN_LO: if (fire) st_n = ST_LEN_HI;
            ST_LEN_HI: if (fire) st_n = ST_HDR;
            ST_HDR:    if (fire) st_n = ST_CMD;
            ST_CMD: begin
                if (fire) st_n = (remain_q == '0) ? ST_FCS : ST_PAY;
            end
            ST_PAY: begin
                if (fire) begin
                    remain_n = remain_q - ONE;
                    if (remain_q == ONE) st_n = ST_FCS;
                end
            end
            ST_FCS:    if (fire) st_n = ST_IDLE;
            default:   st_n = ST_IDLE;
        endcase
    end

    // Phase and count registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            remain_q <= '0;
        end else begin
            st       <= st_n;
            remain_q <= remain_n;
        end
    end

    assign frame_end = (st == ST_FCS) && fire;

endmodule

// File: rtl/cft_xor_acc.sv
// Module: running XOR accumulator for the check byte. Assumes clear and
// enable never coincide (clear happens at header load, in idle).
module cft_xor_acc #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] acc
);

    // Accumulate each enabled byte; clear at frame start.
    always_ff @(posedge clk) begin
        if (!rst_n)     acc <= '0;
        else if (clear) acc <= '0;
        else if (en)    acc <= acc ^ din;
    end

endmodule

// File: rtl/cft_sync_lock.sv
// Module: blocking-request interlock. Set by acceptance of a blocking request,
// cleared by a response notice; set has priority when both occur together.
module cft_sync_lock (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic locked
);

    // Interlock flag with set-over-clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n)   locked <= 1'b0;
        else if (set) locked <= 1'b1;
        else if (clr) locked <= 1'b0;
    end

endmodule

// File: rtl/cmd_frame_tx.sv
// Module: command frame transmitter top. Captures a header, then drives
// marker, length, class/routing, opcode, payload and XOR check bytes onto a
// valid/ready byte stream. Assumes 9 <= LEN_W <= 16 and a payload source that
// supplies exactly the loaded number of bytes.
module cmd_frame_tx
    import cft_pkg::*;
#(
    parameter int LEN_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hdr_load,
    input  logic [2:0]        hdr_type,
    input  logic [4:0]        hdr_subsys,
    input  logic [7:0]        hdr_cmd,
    input  logic [LEN_W-1:0]  hdr_len,
    output logic              hdr_ready,
    input  logic              pl_valid,
    input  logic [7:0]        pl_data,
    output logic              pl_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    input  logic              tx_ready,
    input  logic              resp_seen,
    output logic              frame_done
);

    localparam int PAD_W = 16 - LEN_W;

    cft_state_e       st;
    logic             frame_end;
    logic             locked;
    logic             hdr_accept;
    logic             tx_fire;
    logic             acc_en;
    logic [7:0]       fcs;
    logic [7:0]       len_hi;
    logic [2:0]       type_q;
    logic [4:0]       sub_q;
    logic [7:0]       cmd_q;
    logic [LEN_W-1:0] len_q;
    logic             done_q;

    // Header acceptance: idle, and not a blocked request.
    assign hdr_ready  = (st == ST_IDLE) && !(hdr_type == TYPE_SREQ && locked);
    assign hdr_accept = hdr_load && hdr_ready;
    assign tx_fire    = tx_valid && tx_ready;

    // Header capture registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            type_q <= '0;
            sub_q  <= '0;
            cmd_q  <= '0;
            len_q  <= '0;
        end else if (hdr_accept) begin
            type_q <= hdr_type;
            sub_q  <= hdr_subsys;
            cmd_q  <= hdr_cmd;
            len_q  <= hdr_len;
        end
    end

    // High length byte, zero-padded above the length width.
    generate
        if (PAD_W == 0) begin : g_full_len
            assign len_hi = len_q[15:8];
        end else begin : g_pad_len
            assign len_hi = {{PAD_W{1'b0}}, len_q[LEN_W-1:8]};
        end
    endgenerate

    // Output byte select per phase.
    always_comb begin
        unique case (st)
            ST_SOF:    tx_data = SOF_BYTE;
            ST_LEN_LO: tx_data = len_q[7:0];
            ST_LEN_HI: tx_data = len_hi;
            ST_HDR:    tx_data = pack_hdr(type_q, sub_q);
            ST_CMD:    tx_data = cmd_q;
            ST_PAY:    tx_data = pl_data;
            ST_FCS:    tx_data = fcs;
            default:   tx_data = 8'h00;
        endcase
    end

    // Valid follows the payload source during payload, else any active phase.
    assign tx_valid = (st == ST_PAY) ? pl_valid : (st != ST_IDLE);
    assign pl_ready = (st == ST_PAY) && tx_ready;

    // Check-byte accumulation covers every byte between marker and check.
    assign acc_en = tx_fire && (st != ST_SOF) && (st != ST_FCS) && (st != ST_IDLE);

    cft_sequencer #(.LEN_W(LEN_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (hdr_accept),
        .len       (hdr_len),
        .fire      (tx_fire),
        .st        (st),
        .frame_end (frame_end)
    );

    cft_xor_acc #(.W(8)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (hdr_accept),
        .en    (acc_en),
        .din   (tx_data),
        .acc   (fcs)
    );

    cft_sync_lock u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (hdr_accept && (hdr_type == TYPE_SREQ)),
        .clr    (resp_seen),
        .locked (locked)
    );

    // Completion pulse one cycle after the check byte handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= frame_end;
    end

    assign frame_done = done_q;

endmodule

// File: rtl/cft_checker.sv
// Module: protocol checker for cmd_frame_tx, bound to the top. Observes
// ports plus the phase and interlock state; drives nothing.
module cft_checker
    import cft_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       hdr_load,
    input logic       hdr_ready,
    input logic [2:0] hdr_type,
    input logic       resp_seen,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic [7:0] tx_data,
    input logic       pl_ready,
    input logic       frame_done,
    input cft_state_e st,
    input logic       locked
);

    // R1: accepted load is followed by the marker byte.
    a_r1_sof_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_load && hdr_ready |=> tx_valid && tx_data == SOF_BYTE);

    // R4: payload source is only taken during the payload phase.
    a_r4_pl_only_in_payload: assert property (@(posedge clk) disable iff (!rst_n)
        pl_ready |-> st == ST_PAY);

    // R6: no header accepted while a frame is in flight.
    a_r6_busy_refuses: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !hdr_ready);

    // R7: interlock refuses a blocking request.
    a_r7_lock_refuses: assert property (@(posedge clk) disable iff (!rst_n)
        locked && hdr_type == TYPE_SREQ |-> !hdr_ready);

    // R8: response notice clears the interlock unless a request is taken now.
    a_r8_resp_clears: assert property (@(posedge clk) disable iff (!rst_n)
        resp_seen && !(hdr_load && hdr_ready && hdr_type == TYPE_SREQ) |=> !locked);

    // R9: completion follows the check byte handshake and lasts one cycle.
    a_r9_done_after_check: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_FCS && tx_valid && tx_ready |=> frame_done);

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    // R10: non-payload byte holds under back-pressure.
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready && st != ST_PAY |=> tx_valid && $stable(tx_data));

endmodule

bind cmd_frame_tx cft_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hdr_load   (hdr_load),
    .hdr_ready  (hdr_ready),
    .hdr_type   (hdr_type),
    .resp_seen  (resp_seen),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .tx_data    (tx_data),
    .pl_ready   (pl_ready),
    .frame_done (frame_done),
    .st         (st),
    .locked     (locked)
);

// File: tb/cmd_frame_tx_test.sv
`timescale 1ns/1ps
module cmd_frame_tx_test;

    localparam int LEN_W = 14;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             hdr_load = 1'b0;
    logic [2:0]       hdr_type = '0;
    logic [4:0]       hdr_subsys = '0;
    logic [7:0]       hdr_cmd = '0;
    logic [LEN_W-1:0] hdr_len = '0;
    logic             hdr_ready;
    logic             pl_valid = 1'b0;
    logic [7:0]       pl_data = '0;
    logic             pl_ready;
    logic             tx_valid;
    logic [7:0]       tx_data;
    logic             tx_ready = 1'b0;
    logic             resp_seen = 1'b0;
    logic             frame_done;

    int n_cmp = 0;
    int n_bad = 0;

    // Reference model state
    logic [7:0] exp_b[$];
    int         exp_k[$];     // 0 fixed, 1 payload, 2 check
    string      exp_tag[$];
    logic [7:0] src_q[$];
    logic [7:0] pend_pl[$];
    bit         m_lock = 0;
    bit         m_done = 0;
    bit         load_acc = 0;
    bit         mon_on = 0;
    bit         pl_hold = 0;
    int         gap_mode = 0;
    bit         e_busy, e_ready, e_valid, e_plr;
    string      rtag;
    logic [7:0] x;

    always #2.5 clk = ~clk;

    cmd_frame_tx #(.LEN_W(LEN_W)) uut (
        .clk(clk), .rst_n(rst_n), .hdr_load(hdr_load), .hdr_type(hdr_type),
        .hdr_subsys(hdr_subsys), .hdr_cmd(hdr_cmd), .hdr_len(hdr_len),
        .hdr_ready(hdr_ready), .pl_valid(pl_valid), .pl_data(pl_data),
        .pl_ready(pl_ready), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .resp_seen(resp_seen), .frame_done(frame_done)
    );

    task automatic chk(input bit ok, input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic push(input logic [7:0] b, input int k, input string tag);
        exp_b.push_back(b);
        exp_k.push_back(k);
        exp_tag.push_back(tag);
    endtask

    // Monitor: mid-cycle comparison against the reference model.
    always @(negedge clk) begin
        load_acc = 0;
        if (rst_n && mon_on) begin
            e_busy  = exp_b.size() > 0;
            e_ready = !e_busy && !(hdr_type == 3'd1 && m_lock);
            rtag    = (m_lock && hdr_type == 3'd1) ? "R7" : (e_busy ? "R6" : "R8");
            chk(hdr_ready == e_ready, rtag, hdr_ready, e_ready);
            e_valid = e_busy && (exp_k[0] != 1 || pl_valid);
            chk(tx_valid == e_valid, "R4 valid", tx_valid, e_valid);
            e_plr   = e_busy && exp_k[0] == 1 && tx_ready;
            chk(pl_ready == e_plr, "R4 pl_ready", pl_ready, e_plr);
            chk(frame_done == m_done, "R9", frame_done, m_done);
            m_done = 0;
            if (tx_valid && tx_ready && e_busy) begin
                chk(tx_data == exp_b[0], exp_tag[0], tx_data, exp_b[0]);
                if (exp_k[0] == 2) m_done = 1;
                if (exp_k[0] == 1) void'(src_q.pop_front());
                void'(exp_b.pop_front());
                void'(exp_k.pop_front());
                void'(exp_tag.pop_front());
            end
            if (hdr_load && e_ready) begin
                load_acc = 1;
                x = 8'h00;
                push(8'hFE, 0, "R1");
                push(hdr_len[7:0], 0, "R2 low");
                push({2'b00, hdr_len[13:8]}, 0, "R2 high");
                push({hdr_type, hdr_subsys}, 0, "R3 class");
                push(hdr_cmd, 0, "R3 cmd");
                x = hdr_len[7:0] ^ {2'b00, hdr_len[13:8]} ^ {hdr_type, hdr_subsys} ^ hdr_cmd;
                foreach (pend_pl[i]) begin
                    push(pend_pl[i], 1, "R4 data");
                    x = x ^ pend_pl[i];
                    src_q.push_back(pend_pl[i]);
                end
                push(x, 2, "R5");
            end
            if (hdr_load && e_ready && hdr_type == 3'd1) m_lock = 1;
            else if (resp_seen) m_lock = 0;
        end
    end

    // Stream drivers, updated just after each rising edge.
    always @(posedge clk) begin
        #1;
        tx_ready = (gap_mode == 0) || ($urandom_range(0, 3) != 0);
        if (src_q.size() > 0 && !pl_hold && (gap_mode == 0 || $urandom_range(0, 2) != 0)) begin
            pl_valid = 1'b1;
            pl_data  = src_q[0];
        end else begin
            pl_valid = 1'b0;
            pl_data  = 8'h00;
        end
    end

    task automatic load(input logic [2:0] t, input logic [4:0] s, input logic [7:0] c,
                        input int len, input int tries);
        pend_pl.delete();
        for (int i = 0; i < len; i++) pend_pl.push_back(8'(c + i * 7 + (i >> 8)));
        @(posedge clk); #1;
        hdr_type = t; hdr_subsys = s; hdr_cmd = c; hdr_len = LEN_W'(len);
        hdr_load = 1'b1;
        for (int n = 0; n < tries; n++) begin
            @(posedge clk);
            if (load_acc) break;
        end
        #1 hdr_load = 1'b0;
    endtask

    task automatic wait_idle();
        while (exp_b.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
    endtask

    task automatic pulse_resp();
        @(posedge clk); #1 resp_seen = 1'b1;
        @(posedge clk); #1 resp_seen = 1'b0;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        // R11: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(tx_valid == 1'b0, "R11 tx_valid", tx_valid, 0);
        chk(pl_ready == 1'b0, "R11 pl_ready", pl_ready, 0);
        chk(frame_done == 1'b0, "R11 frame_done", frame_done, 0);
        hdr_type = 3'd1;
        #0.1 chk(hdr_ready == 1'b1, "R11 hdr_ready", hdr_ready, 1);
        @(posedge clk); #1 rst_n = 1'b1; hdr_type = 3'd0;
        @(negedge clk);
        chk(tx_valid == 1'b0 && hdr_ready == 1'b1, "R11 after release", {tx_valid, hdr_ready}, 2'b01);
        mon_on = 1;

        // Plain frames, no gaps: R1 R2 R3 R4 R5 R9
        gap_mode = 0;
        load(3'd2, 5'h15, 8'h33, 3, 10); wait_idle();
        load(3'd3, 5'h0A, 8'hC4, 0, 10); wait_idle();

        // Gaps on both sides, high length byte non-zero: R2 R4 R10
        gap_mode = 1;
        load(3'd2, 5'h02, 8'h81, 300, 10);
        load(3'd2, 5'h03, 8'h11, 4, 1);   // R6: refused while busy
        wait_idle();

        // Interlock sequence: R7 R8
        load(3'd1, 5'h10, 8'h05, 5, 10); wait_idle();
        load(3'd1, 5'h10, 8'h06, 2, 4);   // refused: interlock set
        load(3'd2, 5'h10, 8'h07, 2, 10);  // other class still allowed
        wait_idle();
        pulse_resp();
        load(3'd1, 5'h10, 8'h08, 1, 10); wait_idle();
        pulse_resp();

        // Payload source withheld mid-frame: R4 stall
        gap_mode = 0;
        load(3'd2, 5'h16, 8'h40, 6, 10);
        pl_hold = 1;
        repeat (15) @(posedge clk);
        pl_hold = 0;
        wait_idle();

        // Full-width length: R2 upper bits zero, R5 over long payload
        load(3'd2, 5'h1F, 8'hA5, 16383, 10); wait_idle();

        mon_on = 0;
        finish_run();
    end

endmodule